// File: doc/BRIEF.md
# Four-Lane Receive Link Sync Monitor

This block sits behind the 8b/10b decoders of a four-lane serial converter receiver. It watches each lane's decoded octet stream after code-group lock and decides when the link has to be brought up again. It drives the active-low synchronisation request back to the transmitter, keeps a sticky record of the reason for the last drop, and counts misplaced alignment characters per lane.

Each lane supplies a decoded octet, a flag that marks the octet as a control character, a valid strobe and a code-group-lock flag. A local octet position counter marks where the multiframe boundaries fall. It is aligned once, on the first rising edge of the frame-timing reference after reset. A multiframe holds 32 frames of one octet each, so it spans 32 octets per lane.

Three events pull the request low while the link is up. The first is any lane losing code-group lock. The second is a lane leaving the comma phase for anything other than the start-of-alignment-sequence character. The third is a lane presenting eight lane-alignment characters in a row away from the last octet of a multiframe. After a drop the request stays low for at least one full multiframe, and it is released only when every lane reports lock again.

Top module: `jrx_sync_monitor`

## Requirements
- R1: After reset `sync_n` is 0, `cause` is 0 and every lane error counter is 0. On the first clock edge after reset at which all four `lane_cgs_ok` bits are 1, `sync_n` goes to 1.
- R2: While `sync_n` is 1, a 0 on any `lane_cgs_ok` bit at a clock edge drives `sync_n` to 0 at that edge and sets `cause` bit 0.
- R3: The comma is control octet 0xBC and the alignment-sequence start is control octet 0x1C. A valid octet following a valid comma on the same lane must be another comma or 0x1C. Anything else, including a data octet of value 0xBC, drives `sync_n` to 0 at that edge while the link is up and sets `cause` bit 1.
- R4: The lane-alignment character is control octet 0x7C, and it is legal only when the position counter is 31. Each misplaced one adds 1 to that lane's error counter, which saturates at its maximum. Control octet 0xFC (frame alignment) is accepted at every position and is never counted.
- R5: The eighth consecutive misplaced 0x7C on one lane drives `sync_n` to 0 and sets `cause` bit 2. Fewer misplaced characters are only counted, and a correctly placed 0x7C restarts the run from zero.
- R6: The position counter becomes 0 at the first clock edge after reset that sees `sysref` high after a cycle of `sysref` low. It then counts 0 to 31 and wraps. Later `sysref` edges are ignored until reset. Before alignment no 0x7C is judged.
- R7: After a trigger edge, `sync_n` stays 0 for 33 clock edges. It returns to 1 at the first edge after that at which all lanes report lock.
- R8: `cause` bits stay set until a cycle with `cause_clr` high clears them. A trigger in that same cycle sets its bit anyway.
- R9: Octets with `lane_vld` low are ignored by every check and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock, one octet per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sysref | input | 1 | Frame-timing reference used once to align the position counter |
| cause_clr | input | 1 | Clears the sticky cause register |
| lane_data | input | 32 | Decoded octets, lane i in bits [8i+7:8i] |
| lane_ctrl | input | 4 | Per-lane control-character flag |
| lane_vld | input | 4 | Per-lane octet valid strobe |
| lane_cgs_ok | input | 4 | Per-lane code-group lock flag |
| sync_n | output | 1 | Active-low synchronisation request to the transmitter |
| cause | output | 3 | Sticky drop cause: bit0 lock loss, bit1 bad comma exit, bit2 misplaced run |
| lane_err_cnt | output | 32 | Saturating misplaced-alignment counters, lane i in bits [8i+7:8i] |

## Verification
The assertions assume that `rst` is high for the first clock edges, so that no history from before reset is used. They also assume that every input changes only away from the rising edge. The stimulus drives all inputs a quarter period after each edge. The random traffic never builds a run of more than six misplaced 0x7C characters. It places correct 0x7C characters only at position 31, so the random phase must never drop the link, and the drops are provoked only by directed sequences.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  localparam logic [7:0] CH_COMMA = 8'hBC;
  localparam logic [7:0] CH_ILA_START = 8'h1C;
  localparam logic [7:0] CH_LANE_ALIGN = 8'h7C;
  localparam logic [7:0] CH_FRAME_ALIGN = 8'hFC;

  localparam int CAUSE_W = 3;
  typedef enum int {
    CAUSE_LOCK = 0,
    CAUSE_COMMA_EXIT = 1,
    CAUSE_MISPLACE = 2
  } cause_idx_e;
endpackage

// File: rtl/jsm_mf_tracker.sv
module jsm_mf_tracker #(
  parameter int MF_LEN = 32,
  localparam int POS_W = $clog2(MF_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sysref,
  output logic             aligned,
  output logic             mf_last,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(MF_LEN - 1);
  logic sref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sref_q  <= 1'b0;
      aligned <= 1'b0;
      pos     <= '0;
    end else begin
      sref_q <= sysref;
      if (!aligned && sysref && !sref_q) begin
        aligned <= 1'b1;
        pos     <= '0;
      end else if (aligned) begin
        pos <= (pos == LAST) ? '0 : pos + 1'b1;
      end
    end
  end

  assign mf_last = aligned && (pos == LAST);

  // R6
  mf_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (aligned && pos == LAST) |=> (pos == '0));
endmodule

// File: rtl/jsm_lane_check.sv
module jsm_lane_check
  import jsm_pkg::*;
#(
  parameter int MISPLACE_LIMIT = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       data,
  input  logic             ctrl,
  input  logic             vld,
  input  logic             cgs_ok,
  input  logic             link_up,
  input  logic             aligned,
  input  logic             mf_last,
  output logic             trig_comma,
  output logic             trig_misplace,
  output logic [CNT_W-1:0] err_cnt
);
  localparam int RUN_W = $clog2(MISPLACE_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(MISPLACE_LIMIT - 1);

  logic             in_comma;
  logic [RUN_W-1:0] run;
  logic act, is_comma, is_start, is_align, misplaced, placed, run_full;

  always_comb begin
    act       = vld && cgs_ok;
    is_comma  = ctrl && (data == CH_COMMA);
    is_start  = ctrl && (data == CH_ILA_START);
    is_align  = ctrl && (data == CH_LANE_ALIGN);
    misplaced = act && aligned && is_align && !mf_last;
    placed    = act && aligned && is_align && mf_last;
    run_full  = misplaced && (run == RUN_TOP);
  end

  assign trig_comma    = link_up && act && in_comma && !is_comma && !is_start;
  assign trig_misplace = link_up && run_full;

  always_ff @(posedge clk) begin
    if (rst || !cgs_ok) begin
      in_comma <= 1'b0;
      run      <= '0;
    end else if (act) begin
      in_comma <= is_comma;
      if (placed || run_full) run <= '0;
      else if (misplaced)     run <= run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_cnt <= '0;
    else if (misplaced && (err_cnt != {CNT_W{1'b1}})) err_cnt <= err_cnt + 1'b1;
  end

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run < RUN_W'(MISPLACE_LIMIT));
  // R4
  err_mono_chk: assert property (@(posedge clk) disable iff (rst)
    err_cnt >= $past(err_cnt));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vld |=> (err_cnt == $past(err_cnt)));
endmodule

// File: rtl/jsm_sync_ctrl.sv
module jsm_sync_ctrl
  import jsm_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int HOLD_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] cgs_ok,
  input  logic [NUM_LANES-1:0] trig_comma,
  input  logic [NUM_LANES-1:0] trig_misplace,
  input  logic                 cause_clr,
  output logic                 sync_n,
  output logic [CAUSE_W-1:0]   cause
);
  localparam int HOLD_W = $clog2(HOLD_LEN + 1);

  logic [HOLD_W-1:0]  hold;
  logic [CAUSE_W-1:0] hit;
  logic               any_hit;

  always_comb begin
    hit = '0;
    hit[CAUSE_LOCK]       = sync_n && !(&cgs_ok);
    hit[CAUSE_COMMA_EXIT] = |trig_comma;
    hit[CAUSE_MISPLACE]   = |trig_misplace;
    any_hit = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_n <= 1'b0;
      hold   <= '0;
      cause  <= '0;
    end else begin
      if (any_hit) begin
        sync_n <= 1'b0;
        hold   <= HOLD_W'(HOLD_LEN);
      end else if (hold != '0) begin
        hold <= hold - 1'b1;
      end else if (&cgs_ok) begin
        sync_n <= 1'b1;
      end
      cause <= (cause_clr ? '0 : cause) | hit;
    end
  end

  // R2
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !(&cgs_ok)) |=> !sync_n);
  // R3
  comma_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (|trig_comma) |=> !sync_n);
  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> ($past(hold) == '0));
  // R8
  cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !cause_clr |=> ((cause & $past(cause)) == $past(cause)));
endmodule

// File: rtl/jrx_sync_monitor.sv
module jrx_sync_monitor
  import jsm_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int FRAMES_PER_MF = 32,
  parameter int OCTETS_PER_FRAME = 1,
  parameter int MISPLACE_LIMIT = 8,
  parameter int CNT_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sysref,
  input  logic                       cause_clr,
  input  logic [NUM_LANES*8-1:0]     lane_data,
  input  logic [NUM_LANES-1:0]       lane_ctrl,
  input  logic [NUM_LANES-1:0]       lane_vld,
  input  logic [NUM_LANES-1:0]       lane_cgs_ok,
  output logic                       sync_n,
  output logic [CAUSE_W-1:0]         cause,
  output logic [NUM_LANES*CNT_W-1:0] lane_err_cnt
);
  localparam int MF_LEN = FRAMES_PER_MF * OCTETS_PER_FRAME;
  localparam int POS_W = $clog2(MF_LEN);

  logic             aligned, mf_last;
  logic [POS_W-1:0] pos;
  logic [NUM_LANES-1:0] trig_comma, trig_misplace;

  jsm_mf_tracker #(.MF_LEN(MF_LEN)) u_mf (
    .clk(clk), .rst(rst), .sysref(sysref),
    .aligned(aligned), .mf_last(mf_last), .pos(pos)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    jsm_lane_check #(.MISPLACE_LIMIT(MISPLACE_LIMIT), .CNT_W(CNT_W)) u_lane (
      .clk(clk), .rst(rst),
      .data(lane_data[g*8 +: 8]), .ctrl(lane_ctrl[g]),
      .vld(lane_vld[g]), .cgs_ok(lane_cgs_ok[g]),
      .link_up(sync_n), .aligned(aligned), .mf_last(mf_last),
      .trig_comma(trig_comma[g]), .trig_misplace(trig_misplace[g]),
      .err_cnt(lane_err_cnt[g*CNT_W +: CNT_W])
    );
  end

  jsm_sync_ctrl #(.NUM_LANES(NUM_LANES), .HOLD_LEN(MF_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .cgs_ok(lane_cgs_ok),
    .trig_comma(trig_comma), .trig_misplace(trig_misplace),
    .cause_clr(cause_clr), .sync_n(sync_n), .cause(cause)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (cause == '0 && lane_err_cnt == '0 && (!sync_n || &$past(lane_cgs_ok))));
endmodule

// File: tb/jrx_sync_monitor_tb.sv
module jrx_sync_monitor_tb;
  localparam int CLK_P = 10;
  localparam int NL = 4;
  localparam int MF = 32;

  logic clk = 1'b0;
  logic rst, sysref, cause_clr;
  logic [NL*8-1:0] lane_data;
  logic [NL-1:0] lane_ctrl, lane_vld, lane_cgs_ok;
  logic sync_n;
  logic [2:0] cause;
  logic [NL*8-1:0] lane_err_cnt;

  int n_tests = 0, n_fail = 0;
  int mpos = 0;
  bit al_m = 0, sref_prev = 0;
  int em[NL];
  int rm[NL];

  always #(CLK_P/2) clk = ~clk;

  jrx_sync_monitor u_dut (
    .clk(clk), .rst(rst), .sysref(sysref), .cause_clr(cause_clr),
    .lane_data(lane_data), .lane_ctrl(lane_ctrl), .lane_vld(lane_vld),
    .lane_cgs_ok(lane_cgs_ok), .sync_n(sync_n), .cause(cause),
    .lane_err_cnt(lane_err_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!al_m && sysref && !sref_prev) begin
      mpos = 0; al_m = 1;
    end else if (al_m) mpos = (mpos + 1) % MF;
    sref_prev = sysref;
    #(CLK_P/4);
  endtask

  task automatic put(int i, logic [7:0] d, logic c, logic v);
    lane_data[i*8 +: 8] = d;
    lane_ctrl[i] = c;
    lane_vld[i] = v;
  endtask

  task automatic all_put(logic [7:0] d, logic c);
    for (int i = 0; i < NL; i++) put(i, d, c, 1'b1);
  endtask

  function automatic int errc(int i);
    return int'(lane_err_cnt[i*8 +: 8]);
  endfunction

  // wait out a hold with all lanes in comma phase; check the release edge (R7)
  task automatic hold_and_release();
    all_put(8'hBC, 1'b1);
    for (int k = 0; k < MF; k++) tick();
    chk("R7 still low at end of hold", int'(sync_n), 0);
    tick();
    chk("R7 released after hold", int'(sync_n), 1);
    all_put(8'h1C, 1'b1);
    tick();
    all_put(8'h00, 1'b0);
  endtask

  task automatic goto_pos(bit want_last);
    while ((mpos == MF - 1) != want_last) tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; sysref = 0; cause_clr = 0;
    lane_data = '0; lane_ctrl = '0; lane_vld = '0; lane_cgs_ok = '0;
    for (int i = 0; i < NL; i++) begin em[i] = 0; rm[i] = 0; end
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 sync_n low without lock", int'(sync_n), 0);
    chk("R1 cause clear", int'(cause), 0);
    chk("R1 counters clear", int'(lane_err_cnt != '0), 0);
    lane_cgs_ok = '1;
    all_put(8'hBC, 1'b1);
    tick();
    chk("R1 sync released on lock", int'(sync_n), 1);
    repeat (3) tick();
    // R6 align
    sysref = 1; tick(); sysref = 0;
    repeat (2) tick();
    // R3 legal exit
    all_put(8'h1C, 1'b1); tick();
    all_put(8'h00, 1'b0); tick();
    chk("R3 comma to start is legal", int'(sync_n), 1);

    // random traffic: never drops the link (R4, R9)
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < NL; i++) begin
        int r = int'($urandom % 16);
        logic [7:0] d = 8'($urandom);
        if (r == 0) put(i, 8'h7C, 1'b1, 1'b0);
        else if (r == 1) put(i, 8'hFC, 1'b1, 1'b1);
        else if (r == 2 && mpos == MF - 1) begin put(i, 8'h7C, 1'b1, 1'b1); rm[i] = 0; end
        else if (r == 3 && mpos != MF - 1 && rm[i] < 6) begin
          put(i, 8'h7C, 1'b1, 1'b1); rm[i]++; em[i]++;
        end else put(i, d, 1'b0, 1'b1);
      end
      tick();
    end
    chk("R4 random keeps link up", int'(sync_n), 1);
    chk("R4 random cause clear", int'(cause), 0);
    for (int i = 0; i < NL; i++) chk("R4 random lane error count", errc(i), em[i]);

    // R4: 0xFC anywhere not counted
    all_put(8'h00, 1'b0);
    put(0, 8'hFC, 1'b1, 1'b1); goto_pos(0); tick();
    chk("R4 frame align not counted", errc(0), em[0]);

    // R5 run handling on lane 2
    goto_pos(1); all_put(8'h7C, 1'b1); tick(); all_put(8'h00, 1'b0);
    for (int k = 0; k < 7; k++) begin
      goto_pos(0); put(2, 8'h7C, 1'b1, 1'b1); tick(); put(2, 8'h00, 1'b0, 1'b1);
    end
    em[2] += 7;
    chk("R5 seven misplaced counted", errc(2), em[2]);
    chk("R5 seven misplaced no drop", int'(sync_n), 1);
    // R9 invalid octet ignored
    goto_pos(0); put(2, 8'h7C, 1'b1, 1'b0); tick(); put(2, 8'h00, 1'b0, 1'b1);
    chk("R9 invalid octet not counted", errc(2), em[2]);
    chk("R9 invalid octet no drop", int'(sync_n), 1);
    goto_pos(1); put(2, 8'h7C, 1'b1, 1'b1); tick(); put(2, 8'h00, 1'b0, 1'b1);
    chk("R4 placed align not counted", errc(2), em[2]);
    for (int k = 0; k < 7; k++) begin
      goto_pos(0); put(2, 8'h7C, 1'b1, 1'b1); tick(); put(2, 8'h00, 1'b0, 1'b1);
    end
    em[2] += 7;
    chk("R5 run restarted by placed char", int'(sync_n), 1);
    goto_pos(0); put(2, 8'h7C, 1'b1, 1'b1); tick(); put(2, 8'h00, 1'b0, 1'b1);
    em[2] += 1;
    chk("R5 eighth misplaced drops sync", int'(sync_n), 0);
    chk("R5 cause misplace bit", int'(cause), 4);
    chk("R4 eighth counted", errc(2), em[2]);
    hold_and_release();
    chk("R8 cause sticky after release", int'(cause), 4);
    cause_clr = 1; tick(); cause_clr = 0;
    chk("R8 cause cleared", int'(cause), 0);

    // R3 bad exit: lane1 comma then 0x9C control
    all_put(8'hBC, 1'b1); tick();
    all_put(8'h1C, 1'b1); put(1, 8'h9C, 1'b1, 1'b1); tick();
    chk("R3 wrong exit drops sync", int'(sync_n), 0);
    chk("R3 cause comma bit", int'(cause), 2);
    hold_and_release();
    cause_clr = 1; tick(); cause_clr = 0;
    // R3 data octet 0xBC after comma
    all_put(8'hBC, 1'b1); tick();
    all_put(8'h1C, 1'b1); put(3, 8'hBC, 1'b0, 1'b1); tick();
    chk("R3 data 0xBC after comma drops sync", int'(sync_n), 0);
    chk("R3 cause comma bit again", int'(cause), 2);
    hold_and_release();

    // R8 set wins over clear; R2 lock loss
    cause_clr = 1; lane_cgs_ok[0] = 0; tick(); cause_clr = 0; lane_cgs_ok[0] = 1;
    chk("R2 lock loss drops sync", int'(sync_n), 0);
    chk("R8 set wins over clear", int'(cause), 1);
    hold_and_release();

    // R6 later sysref ignored
    goto_pos(0); while (mpos != 10) tick();
    sysref = 1; tick(); sysref = 0; tick();
    goto_pos(1); put(0, 8'h7C, 1'b1, 1'b1); tick(); put(0, 8'h00, 1'b0, 1'b1);
    chk("R6 second sysref ignored", errc(0), em[0]);
    chk("R6 link still up", int'(sync_n), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule